// File: doc/BRIEF.md
# Three-Wire Addressed Control Port

This block is the slave side of a three-wire serial control link with a chip-enable line, a serial clock, a data-in line and an open-drain data-out line. The system clock oversamples all three serial inputs. An address byte comes first in every transfer and picks what happens next:

- One of two 24-bit control banks is loaded.
- A readout word is shifted back to the controller.
- The transfer is ignored.

Written data collects in a shift register. It moves into the chosen bank only when chip enable falls, so a partial transfer never disturbs the fields that downstream divider, counter and port logic decode.

When no transfer is in progress, the data-out line acts as a status pin. A 3-bit selector held in the second bank picks what it shows: the unlock condition, the count-done flag, the level of one of the two bidirectional pins, or nothing. The data-out output is reported as `do_low_o`, where 1 means the line is pulled low and 0 means it is released.

The controller is a finite-state machine with these states:

- `ST_IDLE`: no transfer is in progress.
- `ST_ADDR`: the address byte is being collected.
- `ST_WRITE`: a bank load is in progress.
- `ST_READ`: the readout word is being shifted out.
- `ST_SKIP`: an unknown address was received and the transfer is ignored.

Its transitions are:

- `ST_IDLE` goes to `ST_ADDR` when chip enable rises.
- `ST_ADDR` goes to `ST_WRITE`, `ST_READ` or `ST_SKIP` on the eighth address bit, according to the decoded address.
- Any state other than `ST_IDLE` returns to `ST_IDLE` when chip enable falls.

Top module: `ctl3w_slave`

## Requirements
- R1: After reset, `bank_a_o` equals 1 at bit 19 (crystal select) and 0 everywhere else, `bank_b_o` is all zero (both IO pins are inputs, all ports are open, selector 000) and `do_low_o` is 0.
- R2: Serial data is sampled on the rising edge of the serial clock. An address sent as the bits 0,0,0,1,0,1,0,0 in transmission order, followed by 24 data bits, loads `bank_a_o` when chip enable falls. The first data bit goes to bit 0.
- R3: The address 1,0,0,1,0,1,0,0 in transmission order, followed by 24 data bits, loads `bank_b_o` in the same way.
- R4: A bank changes only when chip enable falls. A write with fewer than 24 data bits leaves both banks unchanged. Data bits beyond the 24th are ignored.
- R5: A transfer whose address matches no known code leaves both banks unchanged and keeps data-out released.
- R6: While chip enable is high during an address or write phase, `do_low_o` is 0 whatever the selector holds.
- R7: In idle with selector `bank_b_o[2:0]` = 001, `do_low_o` follows `unlock_i`.
- R8: In idle with selector 010, `do_low_o` follows `cnt_done_i`.
- R9: Selector 101 makes `do_low_o` = NOT `io1_pin_i` when direction bit `bank_b_o[3]` is 0 (input), and 0 when that bit is 1 (output). Selector 110 does the same with `io2_pin_i` and `bank_b_o[4]`.
- R10: In idle, selectors 000, 011, 100 and 111 give `do_low_o` = 0.
- R11: The address 0,1,0,1,0,1,0,0 starts a readout. The word is captured on the last address bit and is, in output order: IO1 level, IO2 level, lock flag (NOT `unlock_i`), then `cnt_val_i` MSB first. It is sent with a high bit as released and a low bit as pulled low. Each serial clock rising edge advances one bit, and the line is released after the word ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low reset, applies power-on defaults |
| ce_i | input | 1 | Chip enable, high during a transfer |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| unlock_i | input | 1 | Unlock condition from the loop detector |
| cnt_done_i | input | 1 | Frequency counter measurement finished |
| io1_pin_i | input | 1 | Level at bidirectional pin 1 |
| io2_pin_i | input | 1 | Level at bidirectional pin 2 |
| cnt_val_i | input | CNT_W | Frequency counter result |
| bank_a_o | output | BANK_W | First control bank (divisor, path, reference fields) |
| bank_b_o | output | BANK_W | Second control bank (ports, directions, selector) |
| do_low_o | output | 1 | 1 pulls the open-drain data-out low |

## Verification
The status multiplexer is swept over all eight selector codes, all four direction settings and all sixteen combinations of unlock, count-done and the two pin levels. This separates codes that follow a source, codes that are always released, and pins masked by an output direction.

Writes use distinct data patterns for both bank addresses, so a bit-order or bank-swap error shows up. Near-miss addresses, short transfers and long transfers separate the address decode from the bit-count gate.

Two readouts with different pin, lock and counter values distinguish the word order, and they confirm that the line is released after the last bit.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_WRITE = 3'd2,
        ST_READ  = 3'd3,
        ST_SKIP  = 3'd4
    } st_t;

    // Bit positions that neighbouring logic decodes
    localparam int XTAL_BIT = 19;  // bank A: crystal select, 1 after reset
    localparam int SEL_LSB  = 0;   // bank B: 3-bit data-out selector
    localparam int DIR1_BIT = 3;   // bank B: IO1 direction, 1 = output
    localparam int DIR2_BIT = 4;   // bank B: IO2 direction, 1 = output
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic s1, s2, s3;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[i]  = s2;
        assign rise[i] = s2 & ~s3;
        assign fall[i] = ~s2 & s3;
    end
endmodule

// File: rtl/ctl3w_dout_sel.sv
module ctl3w_dout_sel (
    input  logic [2:0] sel,
    input  logic       dir1,
    input  logic       dir2,
    input  logic       unlock,
    input  logic       cnt_done,
    input  logic       pin1,
    input  logic       pin2,
    output logic       low
);
    always_comb begin
        case (sel)
            3'b001:  low = unlock;
            3'b010:  low = cnt_done;
            3'b101:  low = ~dir1 & ~pin1;
            3'b110:  low = ~dir2 & ~pin2;
            default: low = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave #(
    parameter int BANK_W = 24,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 20,
    parameter logic [ADDR_W-1:0] ADDR_A = 'h28,
    parameter logic [ADDR_W-1:0] ADDR_B = 'h29,
    parameter logic [ADDR_W-1:0] ADDR_R = 'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              unlock_i,
    input  logic              cnt_done_i,
    input  logic              io1_pin_i,
    input  logic              io2_pin_i,
    input  logic [CNT_W-1:0]  cnt_val_i,
    output logic [BANK_W-1:0] bank_a_o,
    output logic [BANK_W-1:0] bank_b_o,
    output logic              do_low_o
);
    import ctl3w_pkg::*;

    localparam int ACW  = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
    localparam int DCW  = $clog2(BANK_W + 1);
    localparam int RD_W = 3 + CNT_W;
    localparam logic [BANK_W-1:0] BANK_A_RST = {{(BANK_W-1){1'b0}}, 1'b1} << XTAL_BIT;
    localparam logic [BANK_W-1:0] BANK_B_RST = '0;

    st_t st, st_nx;

    logic [2:0] ln_lvl, ln_rise, ln_fall;
    logic ce_rise, ce_fall, sck_rise, sdi_lvl;

    logic [ADDR_W-1:0] addr_sr, addr_full;
    logic [ACW-1:0]    acnt;
    logic [BANK_W-1:0] data_sr;
    logic [DCW-1:0]    dcnt;
    logic [RD_W-1:0]   rd_sr;
    logic              bank_sel_b;
    logic              addr_done;
    logic              mux_low;

    ctl3w_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sdi_i, sck_i, ce_i}),
        .lvl  (ln_lvl),
        .rise (ln_rise),
        .fall (ln_fall)
    );

    assign ce_rise  = ln_rise[0];
    assign ce_fall  = ln_fall[0];
    assign sck_rise = ln_rise[1];
    assign sdi_lvl  = ln_lvl[2];

    assign addr_full = {sdi_lvl, addr_sr[ADDR_W-1:1]};
    assign addr_done = (st == ST_ADDR) && !ce_fall && sck_rise
                       && (acnt == ACW'(ADDR_W - 1));

    ctl3w_dout_sel u_dsel (
        .sel     (bank_b_o[SEL_LSB +: 3]),
        .dir1    (bank_b_o[DIR1_BIT]),
        .dir2    (bank_b_o[DIR2_BIT]),
        .unlock  (unlock_i),
        .cnt_done(cnt_done_i),
        .pin1    (io1_pin_i),
        .pin2    (io2_pin_i),
        .low     (mux_low)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (ce_rise) st_nx = ST_ADDR;
            ST_ADDR: begin
                if (ce_fall) st_nx = ST_IDLE;
                else if (addr_done) begin
                    if (addr_full == ADDR_A || addr_full == ADDR_B) st_nx = ST_WRITE;
                    else if (addr_full == ADDR_R)                   st_nx = ST_READ;
                    else                                            st_nx = ST_SKIP;
                end
            end
            ST_WRITE, ST_READ, ST_SKIP: if (ce_fall) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Shift registers, counters and latch banks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_sr    <= '0;
            acnt       <= '0;
            data_sr    <= '0;
            dcnt       <= '0;
            rd_sr      <= '1;
            bank_sel_b <= 1'b0;
            bank_a_o   <= BANK_A_RST;
            bank_b_o   <= BANK_B_RST;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    acnt <= '0;
                    dcnt <= '0;
                end
                ST_ADDR: begin
                    if (sck_rise && !ce_fall) begin
                        addr_sr <= addr_full;
                        acnt    <= acnt + 1'b1;
                    end
                    if (addr_done) begin
                        bank_sel_b <= (addr_full == ADDR_B);
                        if (addr_full == ADDR_R)
                            rd_sr <= {io1_pin_i, io2_pin_i, ~unlock_i, cnt_val_i};
                    end
                end
                ST_WRITE: begin
                    if (ce_fall) begin
                        if (dcnt == DCW'(BANK_W)) begin
                            if (bank_sel_b) bank_b_o <= data_sr;
                            else            bank_a_o <= data_sr;
                        end
                    end else if (sck_rise && dcnt < DCW'(BANK_W)) begin
                        data_sr <= {sdi_lvl, data_sr[BANK_W-1:1]};
                        dcnt    <= dcnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (sck_rise && !ce_fall) rd_sr <= {rd_sr[RD_W-2:0], 1'b1};
                end
                ST_SKIP: ;
                default: ;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) do_low_o <= 1'b0;
        else begin
            unique case (st)
                ST_IDLE: do_low_o <= mux_low;
                ST_READ: do_low_o <= ~rd_sr[RD_W-1];
                default: do_low_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk #(
    parameter int BANK_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input ctl3w_pkg::st_t    st,
    input logic              ce_fall,
    input logic              unlock,
    input logic [BANK_W-1:0] bank_a,
    input logic [BANK_W-1:0] bank_b,
    input logic              do_low
);
    import ctl3w_pkg::*;

    AST_BANK_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_WRITE && ce_fall) |=> $stable(bank_a)); // R4

    AST_BANK_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_WRITE && ce_fall) |=> $stable(bank_b)); // R4

    AST_BUSY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR || st == ST_WRITE || st == ST_SKIP) |=> !do_low); // R6

    AST_UNLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bank_b[2:0] == 3'b001 && unlock) |=> do_low); // R7

    AST_OPEN_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && (bank_b[2:0] == 3'b000 || bank_b[2:0] == 3'b011 ||
                           bank_b[2:0] == 3'b100 || bank_b[2:0] == 3'b111)) |=> !do_low); // R10
endmodule

bind ctl3w_slave ctl3w_chk #(.BANK_W(BANK_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st),
    .ce_fall(ce_fall),
    .unlock (unlock_i),
    .bank_a (bank_a_o),
    .bank_b (bank_b_o),
    .do_low (do_low_o)
);

// File: tb/ctl3w_slave_tb.sv
module ctl3w_slave_tb;
    localparam int BANK_W = 24;
    localparam int CNT_W  = 20;
    localparam int RD_W   = 3 + CNT_W;
    localparam int H      = 6;
    localparam logic [7:0] A_ADDR = 8'h28;  // 0,0,0,1,0,1,0,0 first-sent in bit 0
    localparam logic [7:0] B_ADDR = 8'h29;  // 1,0,0,1,0,1,0,0
    localparam logic [7:0] R_ADDR = 8'h2A;  // 0,1,0,1,0,1,0,0

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic unlock = 1'b0, cnt_done = 1'b0, p1 = 1'b1, p2 = 1'b1;
    logic [CNT_W-1:0] cnt_val = '0;
    logic [BANK_W-1:0] bank_a, bank_b;
    logic do_low;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctl3w_slave u_dut (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sck_i(sck), .sdi_i(sdi),
        .unlock_i(unlock), .cnt_done_i(cnt_done), .io1_pin_i(p1), .io2_pin_i(p2),
        .cnt_val_i(cnt_val), .bank_a_o(bank_a), .bank_b_o(bank_b), .do_low_o(do_low)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ce_up();
        ce = 1'b1;
        wait_clk(H);
    endtask

    task automatic ce_down();
        ce = 1'b0;
        wait_clk(2 * H);
    endtask

    task automatic bit_out(input logic b);
        sdi = b;
        wait_clk(H);
        sck = 1'b1;
        wait_clk(H);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] addr, input logic [39:0] data, input int n);
        ce_up();
        for (int i = 0; i < 8; i++) bit_out(addr[i]);
        for (int i = 0; i < n; i++) bit_out(data[i]);
        wait_clk(H);
        ce_down();
    endtask

    function automatic logic exp_low(input logic [2:0] s, input logic d1, input logic d2,
                                     input logic u, input logic cd, input logic q1, input logic q2);
        case (s)
            3'b001:  return u;
            3'b010:  return cd;
            3'b101:  return !d1 && !q1;
            3'b110:  return !d2 && !q2;
            default: return 1'b0;
        endcase
    endfunction

    task automatic readout(input logic a1, input logic a2, input logic u, input logic [CNT_W-1:0] v);
        logic [RD_W-1:0] w;
        p1 = a1; p2 = a2; unlock = u; cnt_val = v;
        w = {a1, a2, ~u, v};
        ce_up();
        for (int i = 0; i < 8; i++) bit_out(R_ADDR[i]);
        wait_clk(H);
        for (int k = 0; k < RD_W + 2; k++) begin
            logic e;
            e = (k < RD_W) ? ~w[RD_W-1-k] : 1'b0;
            chk($sformatf("R11 bit %0d", k), {31'b0, do_low}, {31'b0, e});
            bit_out(1'b0);
            wait_clk(H);
        end
        ce_down();
        unlock = 1'b0;
    endtask

    initial begin
        logic [BANK_W-1:0] ea, eb;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        chk("R1 bank_a", 32'(bank_a), 32'(24'h080000));
        chk("R1 bank_b", 32'(bank_b), 32'h0);
        chk("R1 do_low", {31'b0, do_low}, 32'h0);

        // R2 / R3 loads with distinct patterns
        xfer(A_ADDR, 40'h00_A5C3_7E, 24); ea = 24'hA5C37E;
        chk("R2 bank_a load 1", 32'(bank_a), 32'(ea));
        chk("R2 bank_b untouched", 32'(bank_b), 32'h0);
        xfer(A_ADDR, 40'h00_1234_81, 24); ea = 24'h123481;
        chk("R2 bank_a load 2", 32'(bank_a), 32'(ea));
        xfer(B_ADDR, 40'h00_F0F0_00, 24); eb = 24'hF0F000;
        chk("R3 bank_b load", 32'(bank_b), 32'(eb));
        chk("R3 bank_a untouched", 32'(bank_a), 32'(ea));

        // R4: no change before CE falls
        ce_up();
        for (int i = 0; i < 8; i++) bit_out(A_ADDR[i]);
        for (int i = 0; i < 24; i++) bit_out(1'b1);
        wait_clk(2 * H);
        chk("R4 hold while ce high", 32'(bank_a), 32'(ea));
        ce_down();
        ea = 24'hFFFFFF;
        chk("R4 latch on ce fall", 32'(bank_a), 32'(ea));
        // R4 short transfer
        xfer(A_ADDR, 40'h00_0000_55, 16);
        chk("R4 short transfer ignored", 32'(bank_a), 32'(ea));
        // R4 long transfer: only first 24 kept
        xfer(B_ADDR, 40'hFF_3C3C_3C, 30); eb = 24'h3C3C3C;
        chk("R4 extra bits ignored", 32'(bank_b), 32'(eb));

        // R5 unknown addresses
        xfer(8'h2C, 40'h00_0000_00, 24);
        xfer(8'hA8, 40'h00_0000_00, 24);
        xfer(8'h2B, 40'h00_0000_00, 24);
        chk("R5 bank_a unchanged", 32'(bank_a), 32'(ea));
        chk("R5 bank_b unchanged", 32'(bank_b), 32'(eb));
        chk("R5 do_low released", {31'b0, do_low}, 32'h0);

        // R6: selector 001 with unlock, line released during a write
        xfer(B_ADDR, 40'h00_0000_01, 24);
        unlock = 1'b1;
        wait_clk(H);
        chk("R7 unlock pulls low", {31'b0, do_low}, 32'h1);
        ce_up();
        for (int i = 0; i < 8; i++) begin
            bit_out(B_ADDR[i]);
            chk("R6 released in address phase", {31'b0, do_low}, 32'h0);
        end
        for (int i = 0; i < 24; i++) begin
            bit_out(i == 0);
            chk("R6 released in write phase", {31'b0, do_low}, 32'h0);
        end
        ce_down();
        unlock = 1'b0;

        // R7..R10 sweep: all selectors, directions, status inputs
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 4; d++) begin
                xfer(B_ADDR, {16'h0, 19'h5A5A, d[1], d[0], s[2:0]} , 24);
                for (int m = 0; m < 16; m++) begin
                    unlock = m[0]; cnt_done = m[1]; p1 = m[2]; p2 = m[3];
                    wait_clk(H);
                    chk($sformatf("R7-R10 sweep sel=%0d dir=%0d in=%0d (R7 R8 R9 R10)", s, d, m),
                        {31'b0, do_low},
                        {31'b0, exp_low(s[2:0], d[0], d[1], m[0], m[1], m[2], m[3])});
                end
            end
        end
        unlock = 1'b0; cnt_done = 1'b0;

        // R11 readouts
        xfer(B_ADDR, 40'h0, 24);
        readout(1'b1, 1'b0, 1'b0, 20'hA5C3E);
        readout(1'b0, 1'b1, 1'b1, 20'h0F1E2);
        chk("R11 bank_b unchanged by readout", 32'(bank_b), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule